// File: doc/BRIEF.md
# Serial Result Port with Frame-Length-Driven Offset Calibration

This block is the digital back end of a 10-bit sampling converter's serial output. Each frame opens when the host pulls the active-low select line low. At that moment the block captures the raw conversion result and subtracts the stored offset correction from it. It clamps the difference into the 10-bit range and places the corrected value in a 12-bit output word. The host then supplies serial clock pulses, and the word leaves on the data line most significant bit first. The block advances one bit on each falling clock edge.

No control register selects calibration. Only the length of the frame decides it. Falling edges 17 through 32 form a calibration window. If the frame reaches the 32nd falling edge, the correction register loads the raw offset measurement, and that value is used from the next frame onward. If the select line rises earlier, the register keeps its old value. The select and serial clock inputs are synchronised into the system clock domain, and every edge is detected there. The data line is shown as a value plus an output enable, so the pad keeps its driver outside this block.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, and whenever the select input is high, `sdo_oe` is 0 (line released), and `cal_busy` and `cal_done` are 0.
- R2: When select falls, the block captures `raw_result` and builds the word {2'b00, corrected[9:0]}. `sdo` shows word bit 11 before the first falling edge. After falling edge k (1 to 11) it shows word bit 11-k, so the line carries 0, 0, D9 down to D0.
- R3: From the 12th falling edge until select rises, `sdo` is 0 while `sdo_oe` is 1.
- R4: The corrected value is `raw_result` minus the stored offset, as a signed integer. It becomes 0 when the difference is negative and 1023 when the difference exceeds 1023.
- R5: `cal_busy` goes to 1 on the 17th falling edge of a frame and returns to 0 on the 32nd falling edge or when select rises, whichever comes first.
- R6: On the 32nd falling edge, the offset register loads `raw_offset`, read as a two's complement value of OFS_W bits. `cal_done` is 1 for exactly one clock cycle. The new value first affects the sample captured in the next frame.
- R7: A frame that ends after fewer than 32 falling edges leaves the offset register unchanged and produces no `cal_done` pulse.
- R8: The edge count stops at 32. Further falling edges in the same frame cause no second load and no second `cal_done` pulse.
- R9: The falling-edge count and the calibration state clear whenever select is high, so every frame counts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| raw_result | input | 10 | Uncorrected conversion result |
| raw_offset | input | OFS_W (6) | Signed raw offset measurement |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for the data pad; 0 means high impedance |
| cal_busy | output | 1 | High while the calibration window is open |
| cal_done | output | 1 | One-cycle pulse when a calibration completes |

## Verification
The bench runs frames of 12, 20, 31, 32 and 40 falling edges. A design that counts the 31st edge as complete, or that reloads on extra clocks, would apply the wrong offset in the following frame. That error shows up directly in the shifted data, so the bench checks the offset through `sdo`. It drives raw results and offsets that push the subtraction below zero and above 1023. Without the clamp, the output would wrap to a large value or to a small one. It also checks that the frame doing the calibration still uses the old offset, and that the pulse is exactly one cycle wide.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
    localparam int FRAME_BITS = 12;  // two lead zeros plus the result
    localparam int CAL_FIRST  = 17;  // falling edge that opens calibration
    localparam int CAL_LAST   = 32;  // falling edge that completes it
    localparam int CNT_W      = $clog2(CAL_LAST + 1);
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= RST_VAL;
                else        r_q <= d_i;
            end
            assign q_o = r_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/adc_offset_corrector.sv
module adc_offset_corrector #(
    parameter int RES_W = 10,
    parameter int OFS_W = 6
) (
    input  logic [RES_W-1:0]        raw_i,
    input  logic signed [OFS_W-1:0] ofs_i,
    output logic [RES_W-1:0]        corr_o
);
    localparam int DW = RES_W + 2;

    logic signed [DW-1:0] raw_ext;
    logic signed [DW-1:0] ofs_ext;
    logic signed [DW-1:0] diff;

    always_comb begin
        raw_ext = signed'({2'b00, raw_i});
        ofs_ext = signed'({{(DW-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
        diff    = raw_ext - ofs_ext;
        if (diff[DW-1]) begin
            corr_o = '0;                       // below zero
        end else if (diff[RES_W]) begin
            corr_o = {RES_W{1'b1}};            // above full scale
        end else begin
            corr_o = diff[RES_W-1:0];
        end
    end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int OFS_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] raw_result,
    input  logic [OFS_W-1:0] raw_offset,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             cal_busy,
    output logic             cal_done
);
    localparam int PAD_W = FRAME_BITS - RES_W;
    localparam logic [CNT_W-1:0] EDGE_LIMIT  = CNT_W'(CAL_LAST);
    localparam logic [CNT_W-1:0] EDGE_OPEN   = CNT_W'(CAL_FIRST);
    localparam logic [CNT_W-1:0] EDGE_WORD   = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic                    in_frame;
        logic                    sclk_prev;
        logic [CNT_W-1:0]        edge_cnt;
        logic [FRAME_BITS-1:0]   word;
        logic                    busy;
        logic                    done;
        logic signed [OFS_W-1:0] offset;
    } port_st_t;

    port_st_t st_d, st_q;

    logic cs_s;
    logic sclk_s;
    logic fall_seen;
    logic [CNT_W-1:0] cnt_next;
    logic [RES_W-1:0] corrected;

    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (cs_n),
        .q_o  (cs_s)
    );

    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (sclk),
        .q_o  (sclk_s)
    );

    adc_offset_corrector #(.RES_W(RES_W), .OFS_W(OFS_W)) u_corr (
        .raw_i (raw_result),
        .ofs_i (st_q.offset),
        .corr_o(corrected)
    );

    assign fall_seen = st_q.sclk_prev & ~sclk_s;
    assign cnt_next  = st_q.edge_cnt + 1'b1;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.sclk_prev = sclk_s;
        if (cs_s) begin
            st_d.in_frame = 1'b0;
            st_d.edge_cnt = '0;
            st_d.busy     = 1'b0;
            st_d.word     = '0;
        end else if (!st_q.in_frame) begin
            st_d.in_frame = 1'b1;
            st_d.edge_cnt = '0;
            st_d.word     = {{PAD_W{1'b0}}, corrected};
        end else if (fall_seen && (st_q.edge_cnt < EDGE_LIMIT)) begin
            st_d.edge_cnt = cnt_next;
            st_d.word     = {st_q.word[FRAME_BITS-2:0], 1'b0};
            if (cnt_next == EDGE_OPEN) begin
                st_d.busy = 1'b1;
            end
            if (cnt_next == EDGE_LIMIT) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.offset = signed'(raw_offset);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo      = st_q.in_frame & st_q.word[FRAME_BITS-1];
    assign sdo_oe   = st_q.in_frame;
    assign cal_busy = st_q.busy;
    assign cal_done = st_q.done;

    AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe && !cal_busy);                                      // R1
    AST_LOW_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && st_q.edge_cnt >= EDGE_WORD) |-> !sdo);                    // R3
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (st_q.edge_cnt >= EDGE_OPEN && st_q.edge_cnt < EDGE_LIMIT)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);                                              // R6
    AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> st_q.edge_cnt == EDGE_LIMIT);                            // R6
    AST_OFFSET_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.offset != $past(st_q.offset)) |-> cal_done);                    // R7
    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.edge_cnt == EDGE_LIMIT && !cs_s) |=> st_q.edge_cnt == EDGE_LIMIT); // R8
    AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> st_q.edge_cnt == '0);                                        // R9
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
    localparam int RES_W = 10;
    localparam int OFS_W = 6;
    localparam int HALF  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b0;
    logic [RES_W-1:0] raw_result = '0;
    logic [OFS_W-1:0] raw_offset = '0;
    logic             sdo, sdo_oe, cal_busy, cal_done;

    int n_cmp = 0;
    int n_bad = 0;
    int done_pulses = 0;
    int model_ofs = 0;

    always #5 clk = ~clk;

    adc_serial_port #(.RES_W(RES_W), .OFS_W(OFS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .raw_result(raw_result), .raw_offset(raw_offset),
        .sdo(sdo), .sdo_oe(sdo_oe), .cal_busy(cal_busy), .cal_done(cal_done)
    );

    always @(posedge clk) if (cal_done) done_pulses++;

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Runs one frame with n falling edges and checks every bit position.
    task automatic frame(input int raw, input int ofs, input int n);
        int e;
        int k_eff;
        e = raw - model_ofs;                         // R4
        if (e < 0) e = 0;
        if (e > 1023) e = 1023;
        done_pulses = 0;
        raw_result  = RES_W'(raw);
        raw_offset  = OFS_W'(ofs);
        cs_n = 1'b0;
        clks(2 * HALF);
        chk(int'(sdo_oe), 1, "R1 enable in frame");
        chk(int'(sdo), 0, "R2 bit before first edge");
        for (int k = 1; k <= n; k++) begin
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
            clks(HALF);
            if (k < 12) chk(int'(sdo), (k < 2) ? 0 : ((e >> (11 - k)) & 1), $sformatf("R2 bit after edge %0d", k));
            else        chk(int'(sdo), 0, $sformatf("R3 low after edge %0d", k));
            k_eff = (k > 32) ? 32 : k;
            chk(int'(cal_busy), (k_eff >= 17 && k_eff < 32) ? 1 : 0, $sformatf("R5 busy after edge %0d", k));
        end
        cs_n = 1'b1;
        clks(2 * HALF);
        chk(int'(sdo_oe), 0, "R1 released after frame");
        chk(int'(cal_busy), 0, "R9 busy cleared");
        if (n >= 32) begin
            chk(done_pulses, 1, "R6/R8 one done pulse");
            model_ofs = ofs;
        end else begin
            chk(done_pulses, 0, "R7 no done on short frame");
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clks(3);
        chk(int'(sdo_oe), 0, "R1 reset enable");
        chk(int'(cal_done), 0, "R1 reset done");
        rst_n = 1'b1;
        clks(4);
        chk(int'(cal_busy), 0, "R1 busy idle");
        frame(677, 0, 12);        // plain readout, zero offset
        frame(3, 5, 32);          // calibrates, uses old offset (R6)
        frame(3, -7, 20);         // clamp low; short frame keeps 5 (R4, R7)
        frame(300, 9, 31);        // 31 edges: still not loaded (R7)
        frame(1023, -7, 40);      // 1018; extra edges ignored (R8)
        frame(1020, 0, 12);       // 1027 clamps to 1023 (R4)
        frame(500, 0, 14);        // 507 (R4, R9 fresh count)
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule